// File: doc/BRIEF.md
# Debug Claim Tag Register Pair

This block holds a small set of claim bits that debug agents use to announce which functions of a trace or debug unit they currently own. Two word-sized registers on a 32-bit register bus give two views of the same bits: a set view, where writing ones marks bits as claimed, and a clear view, where writing ones releases them. The set view always reads back a fixed mask that shows which claim bits exist. The clear view reads back the live claim state.

An agent finds out how many claim bits exist by reading the set view. It takes a claim by writing a one to the set view. It confirms or inspects ownership by reading the clear view, and it gives up a claim by writing a one to the clear view. While the unit's lock status input is high, or while its power status input reports the unit as unpowered, every access is refused. A refused access gets an error response, returns zero data and leaves the claim bits unchanged. The number of implemented claim bits is a parameter, `NUM_CLAIM`, which may range from 4 to 32.

Top module: `claim_tag_regs`

## Requirements
- R1: After reset the response valid flag is 0, and every claim bit is 0 when the clear view is read.
- R2: A read at byte offset 0xFA0 (set view) returns a word whose bits [NUM_CLAIM-1:0] are 1 and whose other bits are 0. The current claim state has no effect on this value.
- R3: A write at offset 0xFA0 sets each implemented claim bit whose write-data bit is 1. Write-data bits that are 0 leave their claim bits unchanged.
- R4: A write at offset 0xFA4 (clear view) clears each claim bit whose write-data bit is 1. Write-data bits that are 0 leave their claim bits unchanged.
- R5: A read at offset 0xFA4 returns the current claim bits in positions [NUM_CLAIM-1:0]. Positions at or above NUM_CLAIM read 0, and writes to those positions have no effect.
- R6: While the lock status input is 1, any access gets an error response with zero read data and leaves the claim bits unchanged.
- R7: While the power status input is 0, any access gets an error response with zero read data and leaves the claim bits unchanged.
- R8: When the lock is clear and the unit is powered, a read at any other offset returns zero without an error, and a write to any other offset has no effect on the claim bits.
- R9: Every request accepted on a clock edge produces exactly one response, valid on the following cycle. The error flag and the read data are valid in that same cycle. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request strobe, one cycle per access |
| req_write | input | 1 | 1 for a write access, 0 for a read access |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| bus_lock | input | 1 | Lock status; 1 refuses every access |
| core_powered | input | 1 | Power status; 0 refuses every access |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data, zero for writes and refused accesses |
| rsp_err | output | 1 | Error response flag |

## Verification
The assertions assume that each `req_valid` pulse is a complete access, with the address, write flag, data, lock and power inputs all stable and meaningful at the sampling edge. They also assume that the lock and power inputs are judged per access, not latched. The bench changes every input only on the falling clock edge and holds it for one full cycle. It then returns `req_valid` to 0 or presents the next access, so no access ever straddles a change of the lock or power inputs. Refused accesses are mixed with normal ones to vary the gating. Claim bits above `NUM_CLAIM` are written with ones so that the clear-view reads can show they stay at zero.

// File: rtl/claim_pkg.sv
package claim_pkg;

    localparam int BUS_W = 32;

    // Decoded form of one bus request
    typedef struct packed {
        logic rd_set;   // read of the set view
        logic rd_clr;   // read of the clear view
        logic wr_set;   // write of the set view
        logic wr_clr;   // write of the clear view
        logic refused;  // access refused by lock or power gating
        logic active;   // a request is present this cycle
    } dec_t;

    // Registered bus response
    typedef struct packed {
        logic             valid;
        logic             err;
        logic [BUS_W-1:0] rdata;
    } resp_t;

    // Ones in the positions of implemented claim bits
    function automatic logic [BUS_W-1:0] impl_mask(input int n);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < BUS_W; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/claim_decode.sv
module claim_decode
    import claim_pkg::*;
#(
    parameter int          ADDR_W  = 12,
    parameter logic [11:0] SET_OFS = 12'hFA0,
    parameter logic [11:0] CLR_OFS = 12'hFA4
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              bus_lock,
    input  logic              core_powered,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

    logic hit_set;
    logic hit_clr;
    logic gate_ok;

    always_comb begin
        hit_set     = (req_addr == SET_A);
        hit_clr     = (req_addr == CLR_A);
        gate_ok     = core_powered && !bus_lock;

        dec         = '0;
        dec.active  = req_valid;
        dec.refused = req_valid && !gate_ok;
        dec.rd_set  = req_valid && gate_ok && !req_write && hit_set;
        dec.rd_clr  = req_valid && gate_ok && !req_write && hit_clr;
        dec.wr_set  = req_valid && gate_ok &&  req_write && hit_set;
        dec.wr_clr  = req_valid && gate_ok &&  req_write && hit_clr;
    end

endmodule

// File: rtl/claim_store.sv
module claim_store
    import claim_pkg::*;
#(
    parameter int NUM_CLAIM = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dec_t             dec,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] claim_q
);

    localparam logic [BUS_W-1:0] MASK = impl_mask(NUM_CLAIM);

    typedef struct packed {
        logic [BUS_W-1:0] claim;
    } st_t;

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d = st_q;
        if (dec.wr_set) begin
            st_d.claim = st_q.claim | (wdata & MASK);
        end else if (dec.wr_clr) begin
            st_d.claim = st_q.claim & ~wdata;
        end
        st_d.claim = st_d.claim & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign claim_q = st_q.claim;

endmodule

// File: rtl/claim_resp.sv
module claim_resp
    import claim_pkg::*;
#(
    parameter int NUM_CLAIM = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dec_t             dec,
    input  logic [BUS_W-1:0] claim_q,
    output resp_t            rsp_q
);

    localparam logic [BUS_W-1:0] MASK = impl_mask(NUM_CLAIM);

    resp_t rsp_d;

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = dec.active;
        rsp_d.err   = dec.refused;
        if (dec.rd_set) begin
            rsp_d.rdata = MASK;
        end else if (dec.rd_clr) begin
            rsp_d.rdata = claim_q & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

endmodule

// File: rtl/claim_tag_regs.sv
module claim_tag_regs
    import claim_pkg::*;
#(
    parameter int          NUM_CLAIM = 6,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SET_OFS   = 12'hFA0,
    parameter logic [11:0] CLR_OFS   = 12'hFA4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              bus_lock,
    input  logic              core_powered,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);

    generate
        if (NUM_CLAIM < 4 || NUM_CLAIM > BUS_W) begin : g_bad_count
            $error("NUM_CLAIM must lie between 4 and 32");
        end
    endgenerate

    dec_t             dec;
    logic [BUS_W-1:0] claim_bits;
    resp_t            rsp_q;

    claim_decode #(
        .ADDR_W  (ADDR_W),
        .SET_OFS (SET_OFS),
        .CLR_OFS (CLR_OFS)
    ) decode_i (
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .bus_lock     (bus_lock),
        .core_powered (core_powered),
        .dec          (dec)
    );

    claim_store #(
        .NUM_CLAIM (NUM_CLAIM)
    ) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .wdata   (req_wdata),
        .claim_q (claim_bits)
    );

    claim_resp #(
        .NUM_CLAIM (NUM_CLAIM)
    ) resp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .claim_q (claim_bits),
        .rsp_q   (rsp_q)
    );

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

endmodule

// File: rtl/claim_tag_regs_chk.sv
module claim_tag_regs_chk #(
    parameter int          NUM_CLAIM = 6,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] SET_OFS   = 12'hFA0,
    parameter logic [11:0] CLR_OFS   = 12'hFA4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              bus_lock,
    input logic              core_powered,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              rsp_err,
    input logic [31:0]       claim_bits
);

    logic [31:0] exp_mask;
    always_comb begin
        for (int i = 0; i < 32; i++) begin
            exp_mask[i] = (i < NUM_CLAIM);
        end
    end

    logic gated;
    logic ours;
    assign gated = bus_lock || !core_powered;
    assign ours  = (req_addr == ADDR_W'(SET_OFS)) || (req_addr == ADDR_W'(CLR_OFS));

    // R9: one response, one cycle after each request
    p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_spurious_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: set view reads the implemented mask
    p_set_read_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !gated && req_addr == ADDR_W'(SET_OFS))
        |=> (rsp_rdata == exp_mask && !rsp_err));

    // R6 / R7: refused access errors and keeps state
    p_gated_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && gated) |=> (rsp_err && rsp_rdata == 32'd0));
    p_gated_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && gated) |=> $stable(claim_bits));

    // R8: other offsets never error and never change state
    p_other_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !gated && !ours) |=> (!rsp_err && rsp_rdata == 32'd0 && $stable(claim_bits)));

    // R5: unimplemented claim positions stay zero
    p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_bits & ~exp_mask) == 32'd0);

endmodule

bind claim_tag_regs claim_tag_regs_chk #(
    .NUM_CLAIM (NUM_CLAIM),
    .ADDR_W    (ADDR_W),
    .SET_OFS   (SET_OFS),
    .CLR_OFS   (CLR_OFS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .bus_lock     (bus_lock),
    .core_powered (core_powered),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_err      (rsp_err),
    .claim_bits   (claim_bits)
);

// File: tb/claim_tag_regs_tb_top.sv
module claim_tag_regs_tb_top;

    localparam int          N_CLAIM = 6;
    localparam int          AW      = 12;
    localparam logic [11:0] A_SET   = 12'hFA0;
    localparam logic [11:0] A_CLR   = 12'hFA4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          bus_lock = 1'b0;
    logic          core_powered = 1'b1;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_err;

    always #4 clk = ~clk;  // 125 MHz

    claim_tag_regs #(
        .NUM_CLAIM (N_CLAIM),
        .ADDR_W    (AW),
        .SET_OFS   (A_SET),
        .CLR_OFS   (A_CLR)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .bus_lock     (bus_lock),
        .core_powered (core_powered),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .rsp_err      (rsp_err)
    );

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    logic [31:0] model = '0;
    logic [31:0] imask = (32'd1 << N_CLAIM) - 32'd1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: presents one access and queues the expected response
    task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       input bit lk, input bit pw, input string tag);
        exp_t e;
        bit   refused;
        @(negedge clk);
        req_valid    = 1'b1;
        req_write    = wr;
        req_addr     = a;
        req_wdata    = d;
        bus_lock     = lk;
        core_powered = pw;
        refused      = lk || !pw;
        e.err   = refused;
        e.rdata = '0;
        e.tag   = tag;
        if (!refused) begin
            if (!wr && a == A_SET) e.rdata = imask;
            else if (!wr && a == A_CLR) e.rdata = model;
            if (wr && a == A_SET) model = model | (d & imask);
            else if (wr && a == A_CLR) model = model & ~d;
        end
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid    = 1'b0;
            bus_lock     = 1'b0;
            core_powered = 1'b1;
        end
    endtask

    // Monitor: compares each response with the queue head
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", {31'd0, rsp_valid}, 32'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_rdata == e.rdata, {e.tag, " rdata"}, rsp_rdata, e.rdata);
                check(rsp_err == e.err, {e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #200000;
        check(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0, "R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0, "R1 valid after reset", {31'd0, rsp_valid}, 32'd0);

        acc(0, A_CLR, 0, 0, 1, "R1 claim after reset");
        acc(0, A_SET, 0, 0, 1, "R2 mask with no claims");
        acc(1, A_SET, 32'h0000_0005, 0, 1, "R3 set write");
        acc(0, A_CLR, 0, 0, 1, "R3 read after set");
        acc(0, A_SET, 0, 0, 1, "R2 mask with claims");
        acc(1, A_SET, 32'h0000_0000, 0, 1, "R3 zero write");
        acc(0, A_CLR, 0, 0, 1, "R3 zeros no effect");
        acc(1, A_SET, 32'hFFFF_FFC2, 0, 1, "R5 upper bits write");
        acc(0, A_CLR, 0, 0, 1, "R5 upper bits stay zero");
        acc(1, A_CLR, 32'h0000_0004, 0, 1, "R4 clear write");
        acc(0, A_CLR, 0, 0, 1, "R4 read after clear");
        acc(1, A_CLR, 32'h0000_0000, 0, 1, "R4 zero clear");
        acc(0, A_CLR, 0, 0, 1, "R4 zeros no effect");
        acc(1, A_SET, 32'h0000_0010, 1, 1, "R6 locked set write");
        acc(0, A_CLR, 0, 1, 1, "R6 locked read");
        acc(1, A_CLR, 32'hFFFF_FFFF, 1, 0, "R6 locked unpowered clear");
        acc(0, A_CLR, 0, 0, 1, "R6 state kept");
        acc(1, A_CLR, 32'h0000_0001, 0, 0, "R7 unpowered clear");
        acc(0, A_SET, 0, 0, 0, "R7 unpowered read");
        acc(0, A_CLR, 0, 0, 1, "R7 state kept");
        acc(0, 12'hFA8, 0, 0, 1, "R8 other read");
        acc(1, 12'hFA8, 32'hFFFF_FFFF, 0, 1, "R8 other write");
        acc(1, 12'h000, 32'hFFFF_FFFF, 0, 1, "R8 low write");
        acc(0, A_CLR, 0, 0, 1, "R8 state kept");
        idle(1);
        acc(1, A_CLR, 32'hFFFF_FFFF, 0, 1, "R4 clear all");
        idle(2);
        acc(0, A_CLR, 0, 0, 1, "R9 isolated read");
        idle(1);
        check(rsp_valid == 1'b1, "R9 valid one cycle later", {31'd0, rsp_valid}, 32'd1);
        idle(3);
        check(sb_q.size() == 0, "R9 all responses seen", sb_q.size(), 32'd0);
        finish_run();
    end

endmodule